// File: doc/BRIEF.md
# I/O-Mapped SD Serial Shift Port

This block sits on an 8-bit CPU I/O bus that uses active-low strobes. It carries bytes to and from an SD card over a serial clock line and two data lines. A CPU write to the data offset loads a byte into a shift register in parallel. Bits then leave most significant first on the serial output, and the bits that arrive on the serial input enter at the bottom of the register. When every bit has moved, the CPU reads the captured byte back from the same offset.

A small write-only configuration register selects how the serial clock is made. In automatic mode, a data write starts a burst of exactly eight clock pulses at half the system clock, and the burst then stops by itself. In bit-bang mode, software drives the clock line directly through an active-low configuration bit. Both modes shift the register on the same clock edges. Every bus strobe is turned into a single-cycle event, so a write strobe held for many cycles still produces one load and one burst. The serial clock is produced by a register on the system clock, so it has no runt pulse at the start of a burst.

Top module: `sd_shift_port`

## Requirements
- R1: A bus access is decoded only while iorq_n is low, m1_n is high and address bit 7 is 1. Any access outside this condition changes no state and does not drive the read bus.
- R2: Address bits [1:0] select the target. Offset 0 is the data register, which can be read and written. Offset 1 is the configuration register, which is write-only. Writes to offsets 2 and 3 have no effect.
- R3: A data write loads the byte in parallel. sd_mosi always shows register bit 7. Each shift moves the register left and puts the sampled sd_miso bit into bit 0, so after eight shifts a read of offset 0 returns the eight received bits, first received in bit 7.
- R4: If configuration bit 0 (automatic) is 1 when the data register is written, sd_sclk gives exactly eight pulses, each one system cycle high and one cycle low, and then stays low. The cycle right after the load is low, so there is no partial first pulse.
- R5: One assertion of wr_n produces exactly one load and one burst, however many cycles the strobe is held.
- R6: When the block is not busy, sd_sclk follows the inverse of configuration bit 1 (active-low bit-bang clock), one cycle after the configuration write. These edges shift the register in the same way as a burst does.
- R7: sd_mosi changes only on a falling edge of sd_sclk or after a load. sd_miso is sampled when sd_sclk rises.
- R8: busy is high from the cycle after the load until the eighth falling edge, which is 16 system cycles in all.
- R9: A data write while busy is ignored. The current burst and its output byte go on unchanged.
- R10: Reset stops any burst, drives sd_sclk and busy low, and sets the configuration to automatic off and bit-bang clock inactive (bit 1 = 1).
- R11: io_rd_oe is high only during a decoded read of offset 0 with rd_n low. Otherwise io_rd_oe is low and io_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with the CPU bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | CPU I/O address |
| io_wdata | input | 8 | CPU write data |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode-fetch marker, active low; it must be high for an access |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_rdata | output | 8 | Read data, zero when not enabled |
| io_rd_oe | output | 1 | Read-bus drive enable |
| sd_sclk | output | 1 | Serial clock to the card |
| sd_mosi | output | 1 | Serial data to the card |
| sd_miso | input | 1 | Serial data from the card |
| busy | output | 1 | Automatic burst in progress |

## Verification
The assertions assume that the bus strobes and sd_miso are synchronous to clk. They also assume that software never asks for an automatic burst while bit-bang is active, and that it keeps the bit-bang bit high (inactive) whenever the automatic bit is in use. The stimulus changes every input only at the falling clock edge. It sets the configuration to either automatic-only or bit-bang-only before it moves any data, and it models sd_miso as a card that presents its next bit after each rising edge of sd_sclk.

// File: rtl/sdsh_pkg.sv
package sdsh_pkg;
  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_CFG  = 2'd1;
  localparam int CFG_AUTO_BIT = 0;
  localparam int CFG_BBN_BIT  = 1;

  typedef struct packed {
    logic bb_n;
    logic auto_en;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{bb_n: 1'b1, auto_en: 1'b0};
endpackage

// File: rtl/sdsh_bus_decode.sv
module sdsh_bus_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              data_wr,
  output logic              cfg_wr,
  output logic              data_rd
);
  import sdsh_pkg::*;

  logic       sel;
  logic       wr_act;
  logic       wr_act_q;
  logic       wr_pulse;
  logic [1:0] off;
  logic       unused_addr_bits;

  assign unused_addr_bits = ^addr[ADDR_W-2:2];

  always_comb begin
    off      = addr[1:0];
    sel      = !iorq_n && m1_n && addr[ADDR_W-1];
    wr_act   = sel && !wr_n;
    wr_pulse = wr_act && !wr_act_q;
    data_wr  = wr_pulse && (off == OFF_DATA);
    cfg_wr   = wr_pulse && (off == OFF_CFG);
    data_rd  = sel && !rd_n && (off == OFF_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  // R5: a write event lasts a single cycle even when the strobe is held
  p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || cfg_wr) |=> !(data_wr || cfg_wr));
endmodule

// File: rtl/sdsh_cfg.sv
module sdsh_cfg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] wdata,
  output sdsh_pkg::cfg_t    cfg
);
  import sdsh_pkg::*;

  cfg_t cfg_q;
  cfg_t cfg_d;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^wdata[DATA_W-1:2];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) begin
      cfg_d.auto_en = wdata[CFG_AUTO_BIT];
      cfg_d.bb_n    = wdata[CFG_BBN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R2: configuration only changes on a decoded configuration write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: rtl/sdsh_shifter.sv
module sdsh_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              auto_en,
  input  logic              bb_n,
  input  logic              sdi,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo,
  output logic              sclk,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sclk_q, sclk_d;
  logic              busy_q, busy_d;
  logic              smp_q, smp_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    smp_d  = smp_q;
    if (load && !busy_q) begin
      sh_d   = wdata;
      busy_d = auto_en;
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else begin
      if (busy_q) begin
        sclk_d = !sclk_q;
        if (sclk_q) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) busy_d = 1'b0;
        end
      end else begin
        sclk_d = !bb_n;
      end
      if (!sclk_q && sclk_d) smp_d = sdi;
      if (sclk_q && !sclk_d) sh_d = {sh_q[DATA_W-2:0], smp_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
      smp_q  <= smp_d;
    end
  end

  assign shreg = sh_q;
  assign sdo   = sh_q[DATA_W-1];
  assign sclk  = sclk_q;
  assign busy  = busy_q;

  // R4: the burst counter never passes the byte width
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DATA_W));
  // R4: during a burst the clock toggles every cycle (half rate)
  p_sclk_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (sclk_q != $past(sclk_q)));
  // R4: no partial pulse, the first burst cycle is low
  p_first_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !sclk_q);
  // R9: a running burst is never restarted
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/sd_shift_port.sv
module sd_shift_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rd_oe,
  output logic              sd_sclk,
  output logic              sd_mosi,
  input  logic              sd_miso,
  output logic              busy
);
  import sdsh_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_l;
  logic              data_wr;
  logic              cfg_wr;
  logic              data_rd;
  cfg_t              cfg;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  sdsh_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_l),
    .addr    (io_addr),
    .iorq_n  (iorq_n),
    .m1_n    (m1_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .data_wr (data_wr),
    .cfg_wr  (cfg_wr),
    .data_rd (data_rd)
  );

  sdsh_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_l),
    .cfg_wr (cfg_wr),
    .wdata  (io_wdata),
    .cfg    (cfg)
  );

  sdsh_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk     (clk),
    .rst_n   (rst_l),
    .load    (data_wr),
    .wdata   (io_wdata),
    .auto_en (cfg.auto_en),
    .bb_n    (cfg.bb_n),
    .sdi     (sd_miso),
    .shreg   (shreg),
    .sdo     (sd_mosi),
    .sclk    (sd_sclk),
    .busy    (busy)
  );

  assign io_rd_oe = data_rd;
  assign io_rdata = data_rd ? shreg : '0;

  // R11: read bus is quiet whenever the drive enable is low
  p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rst_l)
    !io_rd_oe |-> (io_rdata == '0));
  // R7: serial output only moves on a falling clock or after a load
  p_sdo_edge_r7: assert property (@(posedge clk) disable iff (!rst_l)
    !$stable(sd_mosi) |-> ($fell(sd_sclk) || $past(data_wr)));
endmodule

// File: tb/sd_shift_port_test.sv
module sd_shift_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] io_addr;
  logic [7:0] io_wdata;
  logic       iorq_n, m1_n, rd_n, wr_n;
  logic [7:0] io_rdata;
  logic       io_rd_oe;
  logic       sd_sclk, sd_mosi, sd_miso, busy;

  int errors = 0;
  int checks = 0;
  int rise_cnt = 0;
  int busy_cyc = 0;
  logic [7:0] sdo_cap = 8'h00;
  logic [7:0] pat = 8'h00;
  logic [7:0] rd_val;
  logic       rd_oe_val;

  always #2 clk = !clk;

  sd_shift_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
    .io_rdata(io_rdata), .io_rd_oe(io_rd_oe), .sd_sclk(sd_sclk),
    .sd_mosi(sd_mosi), .sd_miso(sd_miso), .busy(busy)
  );

  // card model: next bit after each rising serial clock
  assign sd_miso = (rise_cnt < 8) ? pat[3'(7 - rise_cnt)] : 1'b0;

  always @(posedge sd_sclk) begin
    sdo_cap = {sdo_cap[6:0], sd_mosi};
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge clk) if (busy) busy_cyc = busy_cyc + 1;

  // {addr, write byte, card byte}
  localparam logic [23:0] VEC [6] = '{
    24'h80_A5_3C, 24'hFC_00_FF, 24'h84_FF_00,
    24'hF0_81_7E, 24'h8C_5A_C3, 24'hB8_01_80
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [7:0] p);
    @(posedge clk); #1;
    rise_cnt = 0; busy_cyc = 0; sdo_cap = 8'h00; pat = p;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d,
                          input int hold, input logic m1);
    @(negedge clk);
    io_addr = a; io_wdata = d; iorq_n = 1'b0; wr_n = 1'b0; m1_n = m1;
    repeat (hold) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic io_read(input logic [7:0] a);
    @(negedge clk);
    io_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    #1;
    rd_val = io_rdata; rd_oe_val = io_rd_oe;
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
    iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(sd_sclk == 1'b0 && busy == 1'b0, "R10 reset outputs", {sd_sclk, busy}, 0);
    check(io_rd_oe == 1'b0 && io_rdata == 8'h00, "R11 idle read bus", io_rdata, 0);

    io_write(8'h81, 8'h03, 1, 1'b1); // auto on, bit-bang inactive

    for (int i = 0; i < 6; i++) begin
      clear_mon(VEC[i][7:0]);
      io_write(VEC[i][23:16], VEC[i][15:8], 1 + 3 * i, 1'b1);
      repeat (24) @(negedge clk);
      check(rise_cnt == 8, "R4 pulse count", rise_cnt, 8);
      check(rise_cnt == 8, "R5 one burst per held strobe", rise_cnt, 8);
      check(busy_cyc == 16, "R8 busy length", busy_cyc, 16);
      check(sdo_cap == VEC[i][15:8], "R3 serial out MSB first", sdo_cap, VEC[i][15:8]);
      io_read(8'h80);
      check(rd_oe_val == 1'b1, "R11 read enable offset 0", rd_oe_val, 1);
      check(rd_val == VEC[i][7:0], "R3 captured byte", rd_val, VEC[i][7:0]);
      check(rd_val == VEC[i][7:0], "R7 sample on rising edge", rd_val, VEC[i][7:0]);
    end

    // R1: a7 clear, then m1_n low: no load, no burst
    clear_mon(8'h00);
    io_write(8'h00, 8'h12, 1, 1'b1);
    io_write(8'h80, 8'h34, 1, 1'b0);
    repeat (20) @(negedge clk);
    check(rise_cnt == 0 && busy_cyc == 0, "R1 undecoded write", rise_cnt, 0);
    io_read(8'h80);
    check(rd_val == 8'h80, "R1 register untouched", rd_val, 8'h80);
    io_read(8'h00);
    check(rd_oe_val == 1'b0 && rd_val == 8'h00, "R1 undecoded read", rd_val, 0);

    // R2: offsets 2/3 inert, offset 1 not readable
    io_write(8'h82, 8'h99, 1, 1'b1);
    io_write(8'h83, 8'h00, 1, 1'b1);
    repeat (20) @(negedge clk);
    check(rise_cnt == 0, "R2 offset 2/3 no burst", rise_cnt, 0);
    io_read(8'h80);
    check(rd_val == 8'h80, "R2 offset 2/3 no effect", rd_val, 8'h80);
    io_read(8'h81);
    check(rd_oe_val == 1'b0 && rd_val == 8'h00, "R2/R11 cfg write-only", rd_val, 0);
    // offset 3 with 0 must not have cleared auto: a burst still runs
    clear_mon(8'h11);
    io_write(8'h80, 8'hE7, 1, 1'b1);
    repeat (24) @(negedge clk);
    check(rise_cnt == 8 && sdo_cap == 8'hE7, "R2 cfg kept after offset 3", sdo_cap, 8'hE7);

    // R9: write while busy ignored
    clear_mon(8'h5C);
    io_write(8'h80, 8'hC6, 2, 1'b1);
    io_write(8'h80, 8'h39, 2, 1'b1);
    repeat (24) @(negedge clk);
    check(rise_cnt == 8, "R9 pulses unchanged", rise_cnt, 8);
    check(busy_cyc == 16, "R9 busy unchanged", busy_cyc, 16);
    check(sdo_cap == 8'hC6, "R9 first byte kept", sdo_cap, 8'hC6);
    io_read(8'h80);
    check(rd_val == 8'h5C, "R9 capture intact", rd_val, 8'h5C);

    // R6: bit-bang mode
    io_write(8'h81, 8'h02, 1, 1'b1);
    clear_mon(8'h96);
    io_write(8'h80, 8'hB4, 1, 1'b1);
    check(busy == 1'b0 && sd_sclk == 1'b0, "R6 no burst in bit-bang", {busy, sd_sclk}, 0);
    for (int k = 0; k < 8; k++) begin
      io_write(8'h81, 8'h00, 1, 1'b1);
      if (k == 0) check(sd_sclk == 1'b1, "R6 clock follows inverse", sd_sclk, 1);
      io_write(8'h81, 8'h02, 1, 1'b1);
      if (k == 0) check(sd_sclk == 1'b0, "R6 clock returns low", sd_sclk, 0);
    end
    check(rise_cnt == 8 && sdo_cap == 8'hB4, "R6 bit-bang serial out", sdo_cap, 8'hB4);
    io_read(8'h80);
    check(rd_val == 8'h96, "R6 bit-bang capture", rd_val, 8'h96);

    // R10: reset mid-burst
    io_write(8'h81, 8'h03, 1, 1'b1);
    clear_mon(8'h00);
    io_write(8'h80, 8'hFF, 1, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sd_sclk == 1'b0 && busy == 1'b0, "R10 reset stops burst", {sd_sclk, busy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_mon(8'h00);
    io_write(8'h80, 8'h77, 1, 1'b1);
    repeat (20) @(negedge clk);
    check(rise_cnt == 0 && busy_cyc == 0 && sd_sclk == 1'b0,
          "R10 config cleared", rise_cnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule